// File: doc/BRIEF.md
# Crossbar Slave-Port Arbiter

This block decides which of four masters owns one slave port of a four-by-four crossbar. Each port of the crossbar carries 32-bit addresses and 32-bit data. Each master drives a request, a two-bit priority and a completion strobe. When the port is free, the arbiter picks the requester with the largest priority value. The winner keeps the port until it signals completion, and every other requester is told to stall in the meantime. When several requesters share the top priority, the search starts at the master just after the last owner and wraps around. In this way masters of equal rank take turns.

A crossbar instantiates one arbiter per slave port. Because each port has its own arbiter, up to four transfers can be in flight at once, each on a different port. The grant is registered. The owner's index (`grant_id`) drives the read and write data multiplexers of that port. Address decoding and the data path itself are outside this block.

Top module: `xbar_port_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `grant_valid` is 0, `grant` is 0 and `grant_id` is 3, so that master 0 wins the first tie.
- R2: Master i's priority is `prio[2i+1:2i]`, and a larger value wins. An arbitration with requests pending grants the port, from the next cycle on, to a requester whose priority is the largest among the requesters.
- R3: Among requesters that share the largest priority, the winner is the first one met when searching upward from `grant_id`+1, wrapping modulo 4.
- R4: While the owner's `done` bit is 0, `grant_valid` stays 1 and `grant_id` stays unchanged, whatever the other masters request or with what priority.
- R5: Arbitration happens in any cycle where the port is idle, or where the owner's `done` bit is 1. The result is visible from the next cycle on, and the finishing owner may win again.
- R6: `stall[i]` is 1 exactly when `req[i]` is 1 and master i does not hold the grant. The stall responds in the same cycle.
- R7: A `done` bit from a master that does not own the port, or a `done` bit while the port is idle, has no effect on the grant.
- R8: `grant` is one-hot with bit `grant_id` set when `grant_valid` is 1, and all zero otherwise.
- R9: An arbitration with no requests pending leaves `grant_valid` at 0 and keeps `grant_id` at the last granted master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Per-master request for this slave port |
| prio | input | 8 | Two priority bits per master, master i at [2i+1:2i] |
| done | input | 4 | Per-master completion strobe; only the owner's bit counts |
| grant | output | 4 | One-hot grant |
| grant_valid | output | 1 | Port currently owned |
| grant_id | output | 2 | Owner index, or the last owner while idle |
| stall | output | 4 | Requesting masters that do not own the port |

## Verification
The assertions assume that `req`, `prio` and `done` are settled at each rising edge and remain stable during a cycle. They also assume that a master keeps its request high while it owns the port. They do not assume that `done` is raised only by the owner. For that reason the stimulus drives every input away from the clock edge, and it raises `done` on non-owners and on an idle port on purpose. The random part mixes sparse and dense request patterns with priority sets that are often equal, so that both the ranking path and the rotation path are exercised.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

  // Index reached by stepping `off` places after `base` in a ring of `n`.
  function automatic int ring_step(input int base, input int off, input int n);
    return (base + off) % n;
  endfunction

  // True when candidate priority strictly beats the current best.
  function automatic bit beats(input int cand, input int best);
    return cand > best;
  endfunction

endpackage

// File: rtl/arb_prio_rank.sv
module arb_prio_rank #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  output logic [N-1:0]    top_mask
);
  import xbar_arb_pkg::*;

  logic [PW-1:0] best;

  always_comb begin
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && beats(int'(prio[i*PW +: PW]), int'(best)))
        best = prio[i*PW +: PW];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_mask
    assign top_mask[g] = req[g] && (prio[g*PW +: PW] == best);
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N   = 4,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   cand,
  input  logic [IDW-1:0] last_id,
  output logic [IDW-1:0] win_id,
  output logic           win_found
);
  import xbar_arb_pkg::*;

  always_comb begin
    win_id    = last_id;
    win_found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!win_found) begin
        if (cand[ring_step(int'(last_id), k, N)]) begin
          win_id    = IDW'(ring_step(int'(last_id), k, N));
          win_found = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arb_owner_reg.sv
module arb_owner_reg #(
  parameter int N   = 4,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arb_open,
  input  logic           win_found,
  input  logic [IDW-1:0] win_id,
  output logic           own_valid,
  output logic [IDW-1:0] own_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_valid <= 1'b0;
      own_id    <= IDW'(N - 1);
    end else if (arb_open) begin
      own_valid <= win_found;
      if (win_found) own_id <= win_id;
    end
  end
endmodule

// File: rtl/xbar_port_arbiter.sv
module xbar_port_arbiter #(
  parameter int N   = 4,
  parameter int PW  = 2,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  input  logic [N*PW-1:0] prio,
  input  logic [N-1:0]   done,
  output logic [N-1:0]   grant,
  output logic           grant_valid,
  output logic [IDW-1:0] grant_id,
  output logic [N-1:0]   stall
);
  logic [N-1:0]   top_mask;
  logic [IDW-1:0] win_id;
  logic           win_found;
  logic           arb_open;
  logic           own_valid;
  logic [IDW-1:0] own_id;

  arb_prio_rank #(.N(N), .PW(PW)) u_rank (
    .req(req), .prio(prio), .top_mask(top_mask)
  );

  arb_rr_pick #(.N(N)) u_pick (
    .cand(top_mask), .last_id(own_id), .win_id(win_id), .win_found(win_found)
  );

  // Re-arbitrate when idle, or when the current owner signals completion.
  assign arb_open = !own_valid || done[own_id];

  arb_owner_reg #(.N(N)) u_owner (
    .clk(clk), .rst_n(rst_n), .arb_open(arb_open), .win_found(win_found),
    .win_id(win_id), .own_valid(own_valid), .own_id(own_id)
  );

  assign grant_valid = own_valid;
  assign grant_id    = own_id;

  for (genvar g = 0; g < N; g++) begin : g_out
    assign grant[g] = own_valid && (own_id == IDW'(g));
    assign stall[g] = req[g] && !grant[g];
  end
endmodule

// File: rtl/xbar_port_arbiter_chk.sv
module xbar_port_arbiter_chk #(
  parameter int N   = 4,
  parameter int PW  = 2,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   req,
  input logic [N*PW-1:0] prio,
  input logic [N-1:0]   done,
  input logic [N-1:0]   grant,
  input logic           grant_valid,
  input logic [IDW-1:0] grant_id,
  input logic [N-1:0]   stall,
  input logic           arb_open,
  input logic [IDW-1:0] win_id,
  input logic           win_found
);
  logic win_is_max;
  always_comb begin
    win_is_max = 1'b1;
    for (int i = 0; i < N; i++)
      if (req[i] && (prio[i*PW +: PW] > prio[win_id*PW +: PW])) win_is_max = 1'b0;
  end

  // R4
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !done[grant_id]) |=> (grant_valid && $stable(grant_id)));

  // R5
  regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_open && (|req)) |=> (grant_valid && grant_id == $past(win_id)));

  // R9
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_open && !(|req)) |=> (!grant_valid && $stable(grant_id)));

  // R2
  max_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_open && win_found) |-> win_is_max);

  // R8
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (|grant)));

  // R6
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall & grant) == '0) && ((stall & ~req) == '0));
endmodule

bind xbar_port_arbiter xbar_port_arbiter_chk #(.N(N), .PW(PW)) u_chk (.*);

// File: tb/xbar_port_arbiter_tb.sv
module xbar_port_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] req, done, grant, stall;
  logic [7:0] prio;
  logic       grant_valid;
  logic [1:0] grant_id;

  always #2 clk = ~clk;

  xbar_port_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .done(done),
    .grant(grant), .grant_valid(grant_valid), .grant_id(grant_id), .stall(stall)
  );

  int checks = 0, fails = 0, cycles = 0;
  int m_valid = 0, m_last = 3;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Walk the ring from last+1; strictly greater priority replaces the best.
  function automatic int pick(input logic [3:0] r, input logic [7:0] p, input int last);
    int best_i = -1, best_p = -1;
    for (int k = 1; k <= 4; k++) begin
      int idx = (last + k) & 3;
      int pv  = (p >> (2 * idx)) & 3;
      if (r[idx] && pv > best_p) begin best_p = pv; best_i = idx; end
    end
    return best_i;
  endfunction

  function automatic logic [3:0] exp_grant();
    return m_valid ? (4'b1 << m_last) : 4'b0;
  endfunction

  task automatic check_outs(input string tag);
    chk(grant_valid == m_valid[0], {tag, " valid"}, grant_valid, m_valid);
    chk(grant_id == m_last[1:0], {tag, " id"}, grant_id, m_last);
    chk(grant == exp_grant(), {"R8 ", tag, " grant"}, grant, exp_grant());
  endtask

  task automatic step(input logic [3:0] r, input logic [7:0] p, input logic [3:0] d,
                      input string tag);
    int w;
    @(negedge clk);
    req = r; prio = p; done = d;
    #1;
    chk(stall == (r & ~exp_grant()), "R6 stall", stall, r & ~exp_grant());
    if (!m_valid || d[m_last]) begin
      w = pick(r, p, m_last);
      if (w >= 0) begin m_valid = 1; m_last = w; end
      else m_valid = 0;
    end
    @(posedge clk);
    #1;
    check_outs(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    req = '0; prio = '0; done = '0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_outs("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_outs("R1 after reset");

    // R9 idle, no requests; done while idle ignored (R7)
    step(4'b0000, 8'h00, 4'b1111, "R9 R7 idle");
    // R3 all equal: master 0 wins the first tie, then rotation 1,2,3,0
    step(4'b1111, 8'h55, 4'b0000, "R3 first tie");
    step(4'b1111, 8'h55, 4'b0001, "R3 rotate1");
    step(4'b1111, 8'h55, 4'b0010, "R3 rotate2");
    step(4'b1111, 8'h55, 4'b0100, "R3 rotate3");
    step(4'b1111, 8'h55, 4'b1000, "R3 wrap");
    // R4 owner 0 held while higher-priority master 3 requests
    step(4'b1001, 8'hC0, 4'b0000, "R4 hold");
    // R7 done from non-owner 3
    step(4'b1001, 8'hC0, 4'b1000, "R7 foreign done");
    // R5/R2 owner done -> master 3 (prio 3) wins
    step(4'b1001, 8'hC0, 4'b0001, "R5 R2 regrant");
    // R5 owner finishes with nobody asking
    step(4'b0000, 8'h00, 4'b1000, "R5 R9 release");
    // R2 idle pick by priority: m2=3 beats m0=1
    step(4'b0101, 8'h31, 4'b0000, "R2 prio");

    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] r, d;
      logic [7:0] p;
      r = 4'($urandom);
      if (($urandom % 4) == 0) r = 4'b0000;
      p = (($urandom % 3) == 0) ? 8'h00 : 8'($urandom);
      d = 4'($urandom) & 4'($urandom);
      if (m_valid && ($urandom % 3) == 0) d[m_last] = 1'b1;
      step(r, p, d, "R2 R3 R4 R5 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule